// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits on the host side of a PCI bridge. It turns accesses to two CPU registers into configuration read and write cycles. The first register is a 32-bit configuration address that names the bus, device, function and register offset. The second is a 64-bit data window. Software writes the address register first and then touches the data window. The block decodes the stored address into a Type 0 cycle when the bus is the bridge's own, or a Type 1 cycle when the target is on a bus further down. It runs the cycle on a simple request/ready target interface and returns the data. When nothing answers within a set number of cycles, it returns all-ones.

The stored address is native inside the block. Everything seen through the CPU registers is byte-reversed relative to native order. Address register layout (native): offset in bits 7:0, function in bits 11:8 (four bits, so that an illegal function can be expressed), device in bits 16:12, bus in bits 24:17, and bits 31:25 unused. Requests for unreachable local devices, and requests with illegal functions, finish at once without a cycle. After every data-window access the address register returns to zero, so no cycle stays armed.

Top module: `pci_cfg_xlat`

## Requirements
- R1: For the bus number equal to LOCAL_BUS, the cycle is Type 0 (`tgt_type1`=0) and `tgt_addr` = (1 << device) | (function[2:0] << 8) | offset with bits 1:0 forced to 00.
- R2: For any other bus, the cycle is Type 1 (`tgt_type1`=1) and `tgt_addr` = {8'h00, bus, device, function[2:0], offset[7:2], 2'b01}.
- R3: On the local bus, a device number below MIN_DEV (11) runs no cycle. A read returns all-ones in the selected lane with `cfg_err`=0. A write sets `cfg_err`=1.
- R4: A function number above 7 runs no cycle and sets `cfg_err`=1. A read then returns all-ones in the selected lane.
- R5: Offset bit 2 selects the data lane. When it is 1, write data is taken from `reg_wdata[63:32]` and read data appears in `reg_rdata[63:32]`. When it is 0, bits 31:0 are used. The unselected read lane is zero.
- R6: If `tgt_rdy` does not arrive while `tgt_req` has been high for TIMEOUT (16) cycles, the access completes with `cfg_abort`=1 and all-ones read data. A response in the last of those cycles still completes normally.
- R7: Reading the address register (`reg_sel`=0) returns the last value written. After any data-window access it reads as zero.
- R8: CPU-side data is byte-reversed relative to the target side. For example, CPU address 32'h00B0_0000 means device 11, and target data 32'h1122_3344 reads as 32'h4433_2211.
- R9: A data-window access while the address register is zero runs no cycle. A read returns 32'hFFFF_FFFF in the low lane.
- R10: `busy` is high while a cycle runs, and `reg_wait` is high while a request is pending. `reg_done` pulses for one cycle per access. Target outputs stay stable until ready arrives.
- R11: After reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_done` |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_sel | input | 1 | 0 = address register, 1 = data window |
| reg_wdata | input | 64 | Write data (address register uses bits 31:0) |
| reg_rdata | output | 64 | Read data of the last access |
| reg_done | output | 1 | One-cycle completion pulse |
| reg_wait | output | 1 | Request pending, not yet complete |
| busy | output | 1 | Configuration cycle in progress |
| cfg_err | output | 1 | Last data access was rejected |
| cfg_abort | output | 1 | Last data access timed out |
| tgt_req | output | 1 | Configuration cycle request |
| tgt_wr | output | 1 | Cycle is a write |
| tgt_type1 | output | 1 | Cycle is Type 1 |
| tgt_addr | output | 32 | Configuration address word |
| tgt_wdata | output | 32 | Write data, native order |
| tgt_rdy | input | 1 | Target completion |
| tgt_rdata | input | 32 | Read data, native order |

## Verification
The bench looks for several specific corner cases. A response in the sixteenth request cycle must still win over the timeout; a design with an off-by-one counter would abort it. A response one cycle later must abort. Device 10 and device 11 sit either side of the local cutoff; a wrong comparison would run a cycle, or skip one. A function value of 8 must be rejected on a remote bus too. Offsets with bit 2 set, or with low bits set, would expose a swapped lane or an unmasked offset.

// File: rtl/pcx_pkg.sv
package pcx_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_RUN  = 1'b1
   } pcx_state_e;

   typedef struct packed {
      logic [6:0] rsvd;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [3:0] func;
      logic [7:0] offs;
   } pcx_tag_t;

   function automatic logic [31:0] swap32(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

endpackage

// File: rtl/pcx_decode.sv
module pcx_decode
   import pcx_pkg::*;
#(
   parameter int LOCAL_BUS = 0,
   parameter int MIN_DEV   = 11
) (
   input  logic [31:0] areg,
   output logic [31:0] dec_addr,
   output logic        dec_type1,
   output logic        func_bad,
   output logic        dev_low
);
   localparam logic [7:0] LB = LOCAL_BUS[7:0];
   localparam logic [5:0] MD = MIN_DEV[5:0];

   pcx_tag_t tag;
   logic     is_local;
   logic [31:0] t0_word, t1_word;
   logic unused_rsvd;

   assign tag         = pcx_tag_t'(areg);
   assign unused_rsvd = &{1'b0, tag.rsvd};
   assign is_local    = (tag.bus == LB);

   assign t0_word = (32'h1 << tag.dev)
                  | {21'h0, tag.func[2:0], 8'h00}
                  | {24'h0, tag.offs[7:2], 2'b00};
   assign t1_word = {8'h00, tag.bus, tag.dev, tag.func[2:0], tag.offs[7:2], 2'b01};

   assign dec_type1 = !is_local;
   assign dec_addr  = is_local ? t0_word : t1_word;
   assign func_bad  = tag.func[3];
   assign dev_low   = is_local && ({1'b0, tag.dev} < MD);
endmodule

// File: rtl/pcx_lane.sv
module pcx_lane #(
   parameter int LANE_W  = 32,
   parameter bit SWAP_EN = 1'b1
) (
   input  logic [2*LANE_W-1:0] cpu_wdata,
   input  logic                hi_sel,
   input  logic [LANE_W-1:0]   rsp_data,
   output logic [LANE_W-1:0]   tgt_wdata,
   output logic [2*LANE_W-1:0] cpu_rdata
);
   localparam int NB = LANE_W / 8;

   logic [LANE_W-1:0] wsel, rsw;

   assign wsel = hi_sel ? cpu_wdata[2*LANE_W-1:LANE_W] : cpu_wdata[LANE_W-1:0];

   generate
      if (SWAP_EN) begin : g_swap
         for (genvar b = 0; b < NB; b++) begin : g_byte
            assign tgt_wdata[8*b +: 8] = wsel[8*(NB-1-b) +: 8];
            assign rsw[8*b +: 8]       = rsp_data[8*(NB-1-b) +: 8];
         end
      end else begin : g_pass
         assign tgt_wdata = wsel;
         assign rsw       = rsp_data;
      end
   endgenerate

   assign cpu_rdata = hi_sel ? {rsw, {LANE_W{1'b0}}} : {{LANE_W{1'b0}}, rsw};
endmodule

// File: rtl/pcx_abort_timer.sv
module pcx_abort_timer #(
   parameter int TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expire
);
   localparam int CNT_W = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
   end

   assign expire = run && (cnt_q == LAST);
endmodule

// File: rtl/pci_cfg_xlat.sv
module pci_cfg_xlat
   import pcx_pkg::*;
#(
   parameter int TIMEOUT   = 16,
   parameter int LOCAL_BUS = 0,
   parameter int MIN_DEV   = 11,
   parameter bit SWAP_EN   = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_req,
   input  logic        reg_wr,
   input  logic        reg_sel,
   input  logic [63:0] reg_wdata,
   output logic [63:0] reg_rdata,
   output logic        reg_done,
   output logic        reg_wait,
   output logic        busy,
   output logic        cfg_err,
   output logic        cfg_abort,
   output logic        tgt_req,
   output logic        tgt_wr,
   output logic        tgt_type1,
   output logic [31:0] tgt_addr,
   output logic [31:0] tgt_wdata,
   input  logic        tgt_rdy,
   input  logic [31:0] tgt_rdata
);
   localparam int LANE_W = 32;
   localparam int PORT_W = 2 * LANE_W;

   generate
      if (TIMEOUT < 2) begin : g_bad_timeout
         $error("TIMEOUT must be at least 2");
      end
      if (LOCAL_BUS < 0 || LOCAL_BUS > 255) begin : g_bad_bus
         $error("LOCAL_BUS must fit in eight bits");
      end
      if (MIN_DEV < 0 || MIN_DEV > 31) begin : g_bad_dev
         $error("MIN_DEV must be a device number");
      end
   endgenerate

   pcx_state_e        state_q;
   logic [31:0]       addr_q;
   logic [PORT_W-1:0] rdata_q;
   logic              done_q, err_q, abort_q, hi_q, wr_q, type1_q;
   logic [31:0]       taddr_q, twdata_q;

   logic [31:0]       dec_addr;
   logic              dec_type1, func_bad, dev_low;
   logic              expire, accept, cur_hi, running;
   logic [LANE_W-1:0] lane_rsp, lane_wdata;
   logic [PORT_W-1:0] lane_rdata;
   logic [31:0]       addr_in, addr_out;

   pcx_decode #(.LOCAL_BUS(LOCAL_BUS), .MIN_DEV(MIN_DEV)) u_decode (
      .areg      (addr_q),
      .dec_addr  (dec_addr),
      .dec_type1 (dec_type1),
      .func_bad  (func_bad),
      .dev_low   (dev_low)
   );

   pcx_lane #(.LANE_W(LANE_W), .SWAP_EN(SWAP_EN)) u_lane (
      .cpu_wdata (reg_wdata),
      .hi_sel    (cur_hi),
      .rsp_data  (lane_rsp),
      .tgt_wdata (lane_wdata),
      .cpu_rdata (lane_rdata)
   );

   pcx_abort_timer #(.TIMEOUT(TIMEOUT)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (running),
      .expire (expire)
   );

   assign running  = (state_q == ST_RUN);
   assign accept   = reg_req && !done_q && (state_q == ST_IDLE);
   assign cur_hi   = running ? hi_q : addr_q[2];
   assign lane_rsp = (running && tgt_rdy) ? tgt_rdata : {LANE_W{1'b1}};
   assign addr_in  = SWAP_EN ? swap32(reg_wdata[31:0]) : reg_wdata[31:0];
   assign addr_out = SWAP_EN ? swap32(addr_q) : addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         addr_q   <= '0;
         rdata_q  <= '0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         abort_q  <= 1'b0;
         hi_q     <= 1'b0;
         wr_q     <= 1'b0;
         type1_q  <= 1'b0;
         taddr_q  <= '0;
         twdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (!reg_sel) begin
                     if (reg_wr) addr_q  <= addr_in;
                     else        rdata_q <= {{LANE_W{1'b0}}, addr_out};
                     done_q <= 1'b1;
                  end else if (addr_q == '0) begin
                     if (!reg_wr) rdata_q <= lane_rdata;
                     done_q <= 1'b1;
                  end else if (func_bad || dev_low) begin
                     err_q   <= func_bad || reg_wr;
                     abort_q <= 1'b0;
                     if (!reg_wr) rdata_q <= lane_rdata;
                     addr_q  <= '0;
                     done_q  <= 1'b1;
                  end else begin
                     state_q  <= ST_RUN;
                     taddr_q  <= dec_addr;
                     type1_q  <= dec_type1;
                     wr_q     <= reg_wr;
                     twdata_q <= lane_wdata;
                     hi_q     <= addr_q[2];
                     err_q    <= 1'b0;
                     abort_q  <= 1'b0;
                  end
               end
            end
            ST_RUN: begin
               if (tgt_rdy || expire) begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  addr_q  <= '0;
                  abort_q <= !tgt_rdy;
                  if (!wr_q) rdata_q <= lane_rdata;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign reg_rdata = rdata_q;
   assign reg_done  = done_q;
   assign reg_wait  = reg_req && !done_q;
   assign busy      = running;
   assign cfg_err   = err_q;
   assign cfg_abort = abort_q;
   assign tgt_req   = running;
   assign tgt_wr    = wr_q;
   assign tgt_type1 = type1_q;
   assign tgt_addr  = taddr_q;
   assign tgt_wdata = twdata_q;
endmodule

// File: rtl/pcx_cfg_xlat_chk.sv
module pcx_cfg_xlat_chk #(
   parameter int TIMEOUT = 16
) (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_req,
   input logic        reg_wr,
   input logic        reg_sel,
   input logic [63:0] reg_rdata,
   input logic        reg_done,
   input logic        reg_wait,
   input logic        busy,
   input logic        cfg_abort,
   input logic        tgt_req,
   input logic        tgt_type1,
   input logic [31:0] tgt_addr,
   input logic        tgt_rdy
);
   localparam int CW = $clog2(TIMEOUT + 1) + 1;
   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       run_cnt <= '0;
      else if (tgt_req) run_cnt <= run_cnt + 1'b1;
      else              run_cnt <= '0;
   end

   AST_TYPE0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req && !tgt_type1 |-> ($countones(tgt_addr[31:11]) == 1) && (tgt_addr[1:0] == 2'b00)); // R1
   AST_TYPE1_MARK: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req && tgt_type1 |-> tgt_addr[1:0] == 2'b01); // R2
   AST_ABORT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req |-> run_cnt < CW'(TIMEOUT)); // R6
   AST_ABORT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      reg_done && $rose(cfg_abort) && !reg_wr |-> (reg_rdata[31:0] == 32'hFFFF_FFFF) || (reg_rdata[63:32] == 32'hFFFF_FFFF)); // R6
   AST_REQ_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tgt_req) |-> $past(reg_req && reg_sel)); // R9
   AST_BUSY_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      busy && reg_req |-> reg_wait); // R10
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      reg_done |=> !reg_done); // R10
   AST_TGT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_req && !tgt_rdy |=> !tgt_req || $stable(tgt_addr)); // R10
endmodule

bind pci_cfg_xlat pcx_cfg_xlat_chk #(.TIMEOUT(TIMEOUT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_req   (reg_req),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_rdata (reg_rdata),
   .reg_done  (reg_done),
   .reg_wait  (reg_wait),
   .busy      (busy),
   .cfg_abort (cfg_abort),
   .tgt_req   (tgt_req),
   .tgt_type1 (tgt_type1),
   .tgt_addr  (tgt_addr),
   .tgt_rdy   (tgt_rdy)
);

// File: tb/pci_cfg_xlat_tb.sv
module pci_cfg_xlat_tb;
   localparam int TO = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_req = 1'b0, reg_wr = 1'b0, reg_sel = 1'b0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        reg_done, reg_wait, busy, cfg_err, cfg_abort;
   logic        tgt_req, tgt_wr, tgt_type1;
   logic [31:0] tgt_addr, tgt_wdata;
   logic        tgt_rdy = 1'b0;
   logic [31:0] tgt_rdata = '0;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pci_cfg_xlat #(.TIMEOUT(TO)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_done(reg_done), .reg_wait(reg_wait),
      .busy(busy), .cfg_err(cfg_err), .cfg_abort(cfg_abort), .tgt_req(tgt_req), .tgt_wr(tgt_wr),
      .tgt_type1(tgt_type1), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdy(tgt_rdy),
      .tgt_rdata(tgt_rdata)
   );

   typedef struct packed {
      logic       wr;
      logic [7:0] bus;
      logic [4:0] dev;
      logic [3:0] func;
      logic [7:0] off;
      logic [31:0] data;
      logic [7:0] dly;
      logic       ecyc;
      logic       eerr;
      logic       eabort;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 8'd0,   5'd11, 4'd0, 8'h00, 32'h1122_3344, 8'd0,   1'b1, 1'b0, 1'b0},
      '{1'b1, 8'd0,   5'd31, 4'd7, 8'h3C, 32'hA5A5_5A5A, 8'd3,   1'b1, 1'b0, 1'b0},
      '{1'b0, 8'd0,   5'd20, 4'd3, 8'h04, 32'hCAFE_F00D, 8'd5,   1'b1, 1'b0, 1'b0},
      '{1'b0, 8'd5,   5'd3,  4'd2, 8'h10, 32'h0BAD_BEEF, 8'd1,   1'b1, 1'b0, 1'b0},
      '{1'b1, 8'd255, 5'd31, 4'd7, 8'hFC, 32'h1357_9BDF, 8'd2,   1'b1, 1'b0, 1'b0},
      '{1'b0, 8'd0,   5'd10, 4'd0, 8'h00, 32'h0,         8'd0,   1'b0, 1'b0, 1'b0},
      '{1'b1, 8'd0,   5'd0,  4'd1, 8'h04, 32'h7777_0000, 8'd0,   1'b0, 1'b1, 1'b0},
      '{1'b0, 8'd3,   5'd1,  4'd8, 8'h04, 32'h0,         8'd0,   1'b0, 1'b1, 1'b0},
      '{1'b0, 8'd0,   5'd12, 4'd0, 8'h08, 32'h0,         8'hFF,  1'b1, 1'b0, 1'b1},
      '{1'b1, 8'd1,   5'd0,  4'd0, 8'h08, 32'h2468_ACE0, 8'hFF,  1'b1, 1'b0, 1'b1},
      '{1'b0, 8'd0,   5'd11, 4'd5, 8'h03, 32'h89AB_CDEF, 8'd15,  1'b1, 1'b0, 1'b0},
      '{1'b0, 8'd0,   5'd11, 4'd0, 8'h00, 32'h5555_AAAA, 8'd16,  1'b1, 1'b0, 1'b1}
   };

   function automatic logic [31:0] bswap(input logic [31:0] x);
      return {x[7:0], x[15:8], x[23:16], x[31:24]};
   endfunction

   function automatic logic [31:0] exp_word(input vec_t v);
      if (v.bus == 8'd0)
         return (32'h1 << v.dev) | {21'h0, v.func[2:0], 8'h00} | {24'h0, v.off[7:2], 2'b00};
      return {8'h00, v.bus, v.dev, v.func[2:0], v.off[7:2], 2'b01};
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [63:0] rd;
   int          nreq;
   logic [31:0] cap_addr, cap_wdata;
   logic        cap_type1, cap_wr;

   task automatic access(input logic wr, input logic sel, input logic [63:0] wd,
                         input int dly, input logic [31:0] resp);
      bit fin = 1'b0;
      nreq = 0;
      fork
         begin
            @(negedge clk);
            reg_req = 1'b1; reg_wr = wr; reg_sel = sel; reg_wdata = wd;
            for (int k = 0; k < 100; k++) begin
               @(negedge clk);
               if (reg_done) break;
            end
            rd = reg_rdata;
            reg_req = 1'b0;
            fin = 1'b1;
         end
         begin
            while (!fin) begin
               @(negedge clk);
               if (tgt_req && !fin) begin
                  if (nreq == 0) begin
                     cap_addr = tgt_addr; cap_type1 = tgt_type1;
                     cap_wr = tgt_wr; cap_wdata = tgt_wdata;
                     chk(busy && reg_wait, "R10 busy/wait during cycle", {62'h0, busy, reg_wait}, 64'h3);
                  end
                  tgt_rdy = (nreq == dly);
                  tgt_rdata = resp;
                  nreq++;
               end else begin
                  tgt_rdy = 1'b0;
               end
            end
            tgt_rdy = 1'b0;
         end
      join
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11 reset state
      chk({reg_done, busy, cfg_err, cfg_abort, tgt_req, tgt_wr, tgt_type1} == 7'b0 && reg_rdata == 64'h0
          && tgt_addr == 32'h0 && tgt_wdata == 32'h0, "R11 reset outputs",
          {reg_rdata[31:0], tgt_addr}, 64'h0);
      @(negedge clk); rst_n = 1'b1;

      // R9 data access with empty address register
      access(1'b0, 1'b1, 64'h0, 0, 32'h0);
      chk(nreq == 0, "R9 no cycle when unarmed", 64'(nreq), 64'h0);
      chk(rd == 64'h0000_0000_FFFF_FFFF, "R9 unarmed read", rd, 64'h0000_0000_FFFF_FFFF);
      @(negedge clk);
      chk(!reg_done, "R10 done single pulse", {63'h0, reg_done}, 64'h0);

      // R7 address register readback
      access(1'b1, 1'b0, 64'hFFFF_FFFF_1234_5678, 0, 32'h0);
      access(1'b0, 1'b0, 64'h0, 0, 32'h0);
      chk(rd == 64'h0000_0000_1234_5678, "R7 address readback", rd, 64'h0000_0000_1234_5678);

      // R8 literal byte order: CPU 00B00000 = device 11 on local bus
      access(1'b1, 1'b0, 64'h0000_0000_00B0_0000, 0, 32'h0);
      access(1'b0, 1'b1, 64'h0, 0, 32'h1122_3344);
      chk(cap_addr == 32'h0000_0800, "R8 address byte order", {32'h0, cap_addr}, 64'h800);
      chk(rd == 64'h0000_0000_4433_2211, "R8 data byte order", rd, 64'h0000_0000_4433_2211);

      // Vector walk
      for (int i = 0; i < NV; i++) begin
         vec_t v = VEC[i];
         logic [31:0] a = {7'b0, v.bus, v.dev, v.func, v.off};
         logic hi = v.off[2];
         logic [63:0] wd = 64'h0;
         logic [31:0] lane;
         int ereq;
         if (v.wr) wd = hi ? {bswap(v.data), 32'hDEAD_BEEF} : {32'hDEAD_BEEF, bswap(v.data)};
         access(1'b1, 1'b0, {32'h0, bswap(a)}, 0, 32'h0);
         access(v.wr, 1'b1, wd, int'(v.dly), v.data);
         ereq = !v.ecyc ? 0 : (v.eabort ? TO : int'(v.dly) + 1);
         chk(nreq == ereq, v.eabort ? "R6 request cycles" : (v.eerr ? "R4 no cycle" : "R3 cycle count"),
             64'(nreq), 64'(ereq));
         if (v.ecyc) begin
            chk(cap_addr == exp_word(v) && cap_type1 == (v.bus != 8'd0),
                v.bus == 8'd0 ? "R1 type0 address" : "R2 type1 address",
                {31'h0, cap_type1, cap_addr}, {31'h0, v.bus != 8'd0, exp_word(v)});
            chk(cap_wr == v.wr, "R10 target direction", {63'h0, cap_wr}, {63'h0, v.wr});
            if (v.wr)
               chk(cap_wdata == v.data, "R5 write lane", {32'h0, cap_wdata}, {32'h0, v.data});
         end
         if (!v.wr) begin
            lane = (v.ecyc && !v.eabort) ? bswap(v.data) : 32'hFFFF_FFFF;
            chk(rd == (hi ? {lane, 32'h0} : {32'h0, lane}), "R5 read lane",
                rd, hi ? {lane, 32'h0} : {32'h0, lane});
         end
         chk(cfg_err == v.eerr, v.func[3] ? "R4 error flag" : "R3 error flag",
             {63'h0, cfg_err}, {63'h0, v.eerr});
         chk(cfg_abort == v.eabort, "R6 abort flag", {63'h0, cfg_abort}, {63'h0, v.eabort});
         access(1'b0, 1'b0, 64'h0, 0, 32'h0);
         chk(rd == 64'h0, "R7 address cleared", rd, 64'h0);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule